// File: doc/BRIEF.md
# Periodic Alarm Comparator

This unit holds four alarm registers: seconds, minutes, hours and day of month. Each register is written as one BCD byte. Bit 7 of every byte is a "don't care" flag. On each seconds tick from the time-of-day counter, the unit compares the stored alarm against the current BCD time. It raises a single-cycle interrupt pulse when every compared field agrees.

The pattern of the four flags picks the repeat rate. With no flag set, the alarm fires once per month. The other rates are once per day, hour, minute, or every second. Writes whose field value is out of range are dropped, so a bad value never replaces a good alarm setting.

Top module: `alarm_match`

## Requirements
- R1: Four alarm bytes are selected by `wr_sel`: 0 = seconds, 1 = minutes, 2 = hours, 3 = date. Bit 7 of each byte is its flag. Reset clears all four bytes to 8'h00 and holds `alarm_irq` low.
- R2: With no flag set (monthly rate), a tick fires only when all four fields agree. The compared fields are seconds bits 6:0, minutes bits 6:0, hours bits 5:0 and date bits 5:0.
- R3: With only the date flag set (daily rate), the date field is ignored and hours, minutes and seconds must agree.
- R4: With the date and hour flags set and the others clear (hourly rate), only minutes and seconds are compared.
- R5: With the date, hour and minute flags set and the seconds flag clear (per-minute rate), only seconds is compared.
- R6: Any other flag pattern, including all four set, fires on every tick.
- R7: A seconds or minutes write is discarded if bits 6:0 are above 59. The value is read as (bits 6:4)*10 + bits 3:0.
- R8: An hours write is discarded if bits 5:0, read the same way, are above 23.
- R9: A date write is discarded if bits 5:0 are zero.
- R10: `alarm_irq` goes high for exactly one cycle, in the cycle after the clock edge that samples a matching tick. It stays low when there is no tick, even if the time matches.
- R11: A write in the same cycle as a tick does not affect that tick's compare. It takes effect from the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Alarm register write strobe |
| wr_sel | input | 2 | Register select (0 sec, 1 min, 2 hour, 3 date) |
| wr_data | input | 8 | Write byte, bit 7 = flag |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_date | input | 6 | Current day of month, BCD |
| alarm_irq | output | 1 | Alarm event pulse |

## Verification
The single-pulse property assumes that `sec_tick` is never high on two adjacent cycles. A real seconds tick is far sparser than that, and the stimulus always drops the tick for at least two cycles after raising it. The current-time inputs are taken to be legal BCD, with a non-zero date. The stimulus uses only such values, so a reset alarm with date 00 never matches by accident. Writes are applied between ticks, except in the one case that deliberately overlaps a write with a tick.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;

   localparam int NUM_FIELDS = 4;
   localparam int BYTE_W     = 8;
   localparam int CMP_W      = 7;

   // Coarsest compare set first; the numeric order is relied upon.
   typedef enum logic [2:0] {
      RATE_MONTH = 3'd0,
      RATE_DAY   = 3'd1,
      RATE_HOUR  = 3'd2,
      RATE_MIN   = 3'd3,
      RATE_SEC   = 3'd4
   } rate_e;

   function automatic int field_bits(input int idx);
      return (idx < 2) ? 7 : 6;
   endfunction

   function automatic int field_limit(input int idx);
      case (idx)
         0, 1:    return 59;
         2:       return 23;
         default: return 99;
      endcase
   endfunction

   function automatic bit field_zero_bad(input int idx);
      return idx == 3;
   endfunction

   function automatic int bcd_to_int(input logic [7:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction

endpackage

// File: rtl/alarm_field_reg.sv
module alarm_field_reg
   import alarm_match_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int FIELD_W     = 7,
   parameter int MAX_VAL     = 59,
   parameter bit ZERO_BAD    = 1'b0,
   parameter bit CHECK_RANGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] q
);

   if (DATA_W != BYTE_W) begin : g_bad_width
      $error("alarm_field_reg: DATA_W must equal BYTE_W");
   end
   if (FIELD_W < 1 || FIELD_W >= DATA_W) begin : g_bad_field
      $error("alarm_field_reg: FIELD_W must leave room for the flag bit");
   end

   logic [FIELD_W-1:0] fld;
   logic               accept;

   assign fld = wr_data[FIELD_W-1:0];

   if (CHECK_RANGE) begin : g_check
      int value;
      always_comb begin
         value  = bcd_to_int(8'(fld));
         accept = (value <= MAX_VAL) && !(ZERO_BAD && (fld == '0));
      end
   end else begin : g_nocheck
      assign accept = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (wr_stb && accept)
         q <= wr_data;
   end

endmodule

// File: rtl/alarm_rate_decode.sv
module alarm_rate_decode
   import alarm_match_pkg::*;
(
   input  logic [NUM_FIELDS-1:0] flags,
   output rate_e                 rate,
   output logic [NUM_FIELDS-1:0] cmp_en
);

   // flags[0]=sec, [1]=min, [2]=hour, [3]=date
   always_comb begin
      case (flags)
         4'b0000: rate = RATE_MONTH;
         4'b1000: rate = RATE_DAY;
         4'b1100: rate = RATE_HOUR;
         4'b1110: rate = RATE_MIN;
         default: rate = RATE_SEC;
      endcase
   end

   // A field is compared while the rate is at least as coarse as it.
   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_en
      assign cmp_en[i] = (int'(rate) <= NUM_FIELDS - 1 - i);
   end

endmodule

// File: rtl/alarm_compare.sv
module alarm_compare #(
   parameter int NUM_FIELDS = 4,
   parameter int CMP_W      = 7
) (
   input  logic [CMP_W-1:0]      alm [NUM_FIELDS],
   input  logic [CMP_W-1:0]      cur [NUM_FIELDS],
   input  logic [NUM_FIELDS-1:0] cmp_en,
   output logic                  match
);

   logic [NUM_FIELDS-1:0] hit;

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
      assign hit[i] = !cmp_en[i] || (alm[i] == cur[i]);
   end

   assign match = &hit;

endmodule

// File: rtl/alarm_match.sv
module alarm_match
   import alarm_match_pkg::*;
#(
   parameter bit CHECK_RANGE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] wr_sel,
   input  logic [7:0] wr_data,
   input  logic       sec_tick,
   input  logic [6:0] cur_sec,
   input  logic [6:0] cur_min,
   input  logic [5:0] cur_hour,
   input  logic [5:0] cur_date,
   output logic       alarm_irq
);

   localparam int SEL_W = $clog2(NUM_FIELDS);

   if (SEL_W != 2) begin : g_bad_sel
      $error("alarm_match: select width must be 2");
   end

   logic [BYTE_W-1:0]     alm_q [NUM_FIELDS];
   logic [CMP_W-1:0]      alm_f [NUM_FIELDS];
   logic [CMP_W-1:0]      cur_f [NUM_FIELDS];
   logic [NUM_FIELDS-1:0] flags;
   logic [NUM_FIELDS-1:0] cmp_en;
   logic                  match;
   logic                  irq_q;
   rate_e                 rate;

   assign cur_f[0] = cur_sec;
   assign cur_f[1] = cur_min;
   assign cur_f[2] = CMP_W'(cur_hour);
   assign cur_f[3] = CMP_W'(cur_date);

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      localparam int W = field_bits(i);

      alarm_field_reg #(
         .DATA_W     (BYTE_W),
         .FIELD_W    (W),
         .MAX_VAL    (field_limit(i)),
         .ZERO_BAD   (field_zero_bad(i)),
         .CHECK_RANGE(CHECK_RANGE)
      ) u_reg (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_stb (wr_en && (wr_sel == SEL_W'(i))),
         .wr_data(wr_data),
         .q      (alm_q[i])
      );

      assign alm_f[i] = CMP_W'(alm_q[i][W-1:0]);
      assign flags[i] = alm_q[i][BYTE_W-1];
   end

   alarm_rate_decode u_rate (
      .flags (flags),
      .rate  (rate),
      .cmp_en(cmp_en)
   );

   alarm_compare #(
      .NUM_FIELDS(NUM_FIELDS),
      .CMP_W     (CMP_W)
   ) u_cmp (
      .alm   (alm_f),
      .cur   (cur_f),
      .cmp_en(cmp_en),
      .match (match)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else
         irq_q <= sec_tick && match;
   end

   assign alarm_irq = irq_q;

endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [1:0] wr_sel,
   input logic [7:0] wr_data,
   input logic       sec_tick,
   input logic [6:0] cur_sec,
   input logic [6:0] cur_min,
   input logic [5:0] cur_hour,
   input logic [5:0] cur_date,
   input logic       irq,
   input logic [7:0] s_q,
   input logic [7:0] m_q,
   input logic [7:0] h_q,
   input logic [7:0] d_q
);

   logic [7:0] wr_dec7;
   logic [7:0] wr_dec6;

   assign wr_dec7 = 8'(wr_data[6:4]) * 8'd10 + 8'(wr_data[3:0]);
   assign wr_dec6 = 8'(wr_data[5:4]) * 8'd10 + 8'(wr_data[3:0]);

   // R10
   irq_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(sec_tick));

   // R10
   irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R6
   every_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && s_q[7] && m_q[7] && h_q[7] && d_q[7]) |=> irq);

   // R2
   month_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !s_q[7] && !m_q[7] && !h_q[7] && !d_q[7]
       && s_q[6:0] == cur_sec && m_q[6:0] == cur_min
       && h_q[5:0] == cur_hour && d_q[5:0] == cur_date) |=> irq);

   // R7
   sec_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0 && wr_dec7 > 8'd59) |=> $stable(s_q));

   // R8
   hour_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd2 && wr_dec6 > 8'd23) |=> $stable(h_q));

   // R9
   date_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3 && wr_data[5:0] == 6'd0) |=> $stable(d_q));

endmodule

bind alarm_match alarm_match_chk chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_sel  (wr_sel),
   .wr_data (wr_data),
   .sec_tick(sec_tick),
   .cur_sec (cur_sec),
   .cur_min (cur_min),
   .cur_hour(cur_hour),
   .cur_date(cur_date),
   .irq     (alarm_irq),
   .s_q     (alm_q[0]),
   .m_q     (alm_q[1]),
   .h_q     (alm_q[2]),
   .d_q     (alm_q[3])
);

// File: tb/alarm_match_tb.sv
module alarm_match_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 12;

   // {alarm s,m,h,d, current s,m,h,d, expected}
   localparam logic [64:0] VEC [NVEC] = '{
      {8'h30, 8'h45, 8'h12, 8'h15, 8'h30, 8'h45, 8'h12, 8'h15, 1'b1}, // R2
      {8'h30, 8'h45, 8'h12, 8'h15, 8'h30, 8'h45, 8'h12, 8'h16, 1'b0}, // R2
      {8'h30, 8'h45, 8'h12, 8'h15, 8'h31, 8'h45, 8'h12, 8'h15, 1'b0}, // R2
      {8'h30, 8'h45, 8'h12, 8'h95, 8'h30, 8'h45, 8'h12, 8'h20, 1'b1}, // R3
      {8'h30, 8'h45, 8'h12, 8'h95, 8'h30, 8'h45, 8'h13, 8'h20, 1'b0}, // R3
      {8'h30, 8'h45, 8'h92, 8'h95, 8'h30, 8'h45, 8'h07, 8'h03, 1'b1}, // R4
      {8'h30, 8'h45, 8'h92, 8'h95, 8'h30, 8'h44, 8'h07, 8'h03, 1'b0}, // R4
      {8'h30, 8'hC5, 8'h92, 8'h95, 8'h30, 8'h10, 8'h07, 8'h03, 1'b1}, // R5
      {8'h30, 8'hC5, 8'h92, 8'h95, 8'h31, 8'h10, 8'h07, 8'h03, 1'b0}, // R5
      {8'hB0, 8'hC5, 8'h92, 8'h95, 8'h01, 8'h02, 8'h03, 8'h04, 1'b1}, // R6
      {8'hB0, 8'h45, 8'h12, 8'h15, 8'h01, 8'h02, 8'h03, 8'h04, 1'b1}, // R6
      {8'h30, 8'hC5, 8'h12, 8'h95, 8'h00, 8'h00, 8'h00, 8'h01, 1'b1}  // R6
   };
   localparam string VTAG [NVEC] = '{"R2", "R2", "R2", "R3", "R3", "R4",
                                     "R4", "R5", "R5", "R6", "R6", "R6"};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = '0;
   logic [7:0] wr_data = '0;
   logic       sec_tick = 1'b0;
   logic [6:0] cur_sec = '0;
   logic [6:0] cur_min = '0;
   logic [5:0] cur_hour = '0;
   logic [5:0] cur_date = 6'h01;
   logic       alarm_irq;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   alarm_match dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .sec_tick (sec_tick),
      .cur_sec  (cur_sec),
      .cur_min  (cur_min),
      .cur_hour (cur_hour),
      .cur_date (cur_date),
      .alarm_irq(alarm_irq)
   );

   task automatic check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: alarm_irq=%0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_alarm(input logic [7:0] s, m, h, d);
      wr(2'd0, s); wr(2'd1, m); wr(2'd2, h); wr(2'd3, d);
   endtask

   task automatic set_cur(input logic [7:0] s, m, h, d);
      cur_sec = s[6:0]; cur_min = m[6:0]; cur_hour = h[5:0]; cur_date = d[5:0];
   endtask

   task automatic tick_chk(input logic exp, input string tag);
      @(negedge clk);
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
      check(alarm_irq, exp, tag);
      @(negedge clk);
      check(alarm_irq, 1'b0, "R10 pulse width");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  Result: errors=%0d of %0d checks", fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state, zeroed monthly alarm does not match date 01
      check(alarm_irq, 1'b0, "R1 reset irq");
      set_cur(8'h00, 8'h00, 8'h00, 8'h01);
      tick_chk(1'b0, "R1 reset bytes");

      for (int i = 0; i < NVEC; i++) begin
         set_alarm(VEC[i][64:57], VEC[i][56:49], VEC[i][48:41], VEC[i][40:33]);
         set_cur(VEC[i][32:25], VEC[i][24:17], VEC[i][16:9], VEC[i][8:1]);
         tick_chk(VEC[i][0], $sformatf("%s vector %0d", VTAG[i], i));
      end

      // R10: matching time without a tick gives no pulse
      set_alarm(8'h30, 8'h45, 8'h12, 8'h15);
      set_cur(8'h30, 8'h45, 8'h12, 8'h15);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(alarm_irq, 1'b0, "R10 no tick");
      end
      tick_chk(1'b1, "R10 tick fires");

      // R7: out-of-range seconds and minutes are dropped
      wr(2'd0, 8'h5A);
      tick_chk(1'b1, "R7 sec 60 dropped");
      wr(2'd1, 8'h60);
      tick_chk(1'b1, "R7 min 60 dropped");
      wr(2'd0, 8'h59);
      tick_chk(1'b0, "R7 sec 59 accepted");
      wr(2'd0, 8'h30);

      // R8: hours above 23 dropped
      wr(2'd2, 8'h24);
      tick_chk(1'b1, "R8 hour 24 dropped");

      // R9: zero date dropped (flag must not take either)
      wr(2'd3, 8'hC0);
      set_cur(8'h30, 8'h45, 8'h12, 8'h16);
      tick_chk(1'b0, "R9 zero date dropped");
      set_cur(8'h30, 8'h45, 8'h12, 8'h15);
      tick_chk(1'b1, "R9 old date kept");

      // R11: write coinciding with a tick applies from the next tick
      @(negedge clk);
      sec_tick = 1'b1;
      wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h31;
      @(negedge clk);
      sec_tick = 1'b0;
      wr_en = 1'b0;
      check(alarm_irq, 1'b1, "R11 old value used");
      @(negedge clk);
      tick_chk(1'b0, "R11 new value applied");
      set_cur(8'h31, 8'h45, 8'h12, 8'h15);
      tick_chk(1'b1, "R11 new value matches");

      $display("  Result: errors=%0d of %0d checks", fails, checks);
      $finish;
   end

endmodule